// File: doc/BRIEF.md
# GPIO Bank with Blink and Grouped Interrupts

A memory-mapped bank of 32 general purpose pins, programmed through a simple register bus that has a word address, a write strobe, write data and combinational read data. Each pin owns one bit in each of eight registers. These registers hold the driven value, the direction, blink, input inversion, the read-only sampled input, the latched interrupt cause, the edge enable and the level enable.

Pin inputs pass through a two-flop synchroniser and an optional inversion. The result is what software reads, and it also feeds interrupt detection. Because the inversion comes first, rising-edge and high-level logic also serve falling-edge and low-level sources.

Pins are merged eight at a time into four active-high, level-type interrupt lines. Blinking pins share one free-running divider and toggle together.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register reads all ones, so every pin is an input and `pin_oe` is all zeros. Every other writable register and the cause register read zero, and `irq` is zero.
- R2: The register word is selected by `reg_addr[4:2]`: 0 data out, 1 direction, 2 blink enable, 3 input inversion, 4 data in, 5 interrupt cause, 6 edge enable, 7 level enable. Words 0, 1, 2, 3, 6 and 7 read back what was written. A write to word 4 has no effect.
- R3: The direction register is active-low. A 0 bit sets that bit of `pin_oe` to 1, and the pin then drives its data-out bit on `pin_out`. A 1 bit turns the driver off.
- R4: When a pin's blink bit is set, its `pin_out` bit follows a shared phase instead of data out. The phase toggles once every 2^BLINK_BITS clocks, and all blinking pins toggle together.
- R5: Data in reads the twice-registered pin input XOR the inversion bit. A pin change applied before clock edge k becomes readable after edge k+1.
- R6: For a pin whose level-enable bit is clear, a 0-to-1 transition of the adjusted input sets its cause bit. The bit stays set after the input falls.
- R7: A write to the cause register clears each bit written as 0 and keeps each bit written as 1. An edge that arrives in the same cycle as the clear wins.
- R8: For a pin whose level-enable bit is set, the cause bit copies the adjusted input each cycle. Clearing it has no lasting effect while the level stays active.
- R9: Setting the inversion bit makes a falling edge of the raw pin set the cause bit, while a rising edge of the raw pin does not.
- R10: `irq[g]` is 1 exactly when some pin in 8g..8g+7 has its cause bit set together with its edge-enable bit or its level-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | 32 | Raw pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Active-high output driver enables |
| irq | output | 4 | One interrupt line per group of eight pins |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Write to the read-only data-in word.** A design that stored the write would read back ones where the pins are low.
- **Clearing a cause bit while its level is still active.** A design that treated level pins like edge pins would drop the bit and the group line.
- **Inversion as the source of falling edges.** Setting the inversion bit is itself an edge. A raw rising edge must then stay silent, and a raw falling edge must be caught.
- **Cause latched while enables are clear.** Such a pin must not raise its line until an enable bit is set.
- **Blink phase period.** Sampling 2^BLINK_BITS cycles apart exposes a divider that is off by one.

A behavioural model is compared on every cycle during both the directed steps and a random toggling phase.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    W_DOUT  = 3'd0,
    W_DIR   = 3'd1,
    W_BLINK = 3'd2,
    W_INV   = 3'd3,
    W_DIN   = 3'd4,
    W_CAUSE = 3'd5,
    W_EDGE  = 3'd6,
    W_LEVEL = 3'd7
  } reg_word_e;

  function automatic reg_word_e word_of(input logic [ADDR_W-1:0] a);
    return reg_word_e'(a[4:2]);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= '0;
      q2 <= '0;
    end else begin
      q1 <= d;
      q2 <= q1;
    end
  end
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int BITS = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic wrap
);
  logic [BITS-1:0] cnt;

  assign wrap = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) phase <= ~phase;
    end
  end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int PINS  = 32,
  parameter int GROUP = 8,
  localparam int NGRP = PINS / GROUP
) (
  input  logic [PINS-1:0] cause,
  input  logic [PINS-1:0] edge_mask,
  input  logic [PINS-1:0] lvl_mask,
  output logic [NGRP-1:0] irq
);
  function automatic logic [PINS-1:0] armed_bits(input logic [PINS-1:0] c,
                                                 input logic [PINS-1:0] e,
                                                 input logic [PINS-1:0] l);
    return c & (e | l);
  endfunction

  logic [PINS-1:0] armed;
  assign armed = armed_bits(cause, edge_mask, lvl_mask);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign irq[g] = |armed[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS       = 32,
  parameter int GROUP      = 8,
  parameter int BLINK_BITS = 24,
  localparam int NGRP      = PINS / GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [NGRP-1:0]   irq
);
  logic [PINS-1:0] dout, dir_ctl, blink_en, pol, cause, edge_mask, lvl_mask;
  logic [PINS-1:0] sync1, sync2, adj_in, adj_prev, edge_evt, keep;
  logic            blink_phase, blink_wrap, cause_wr;
  reg_word_e       wsel;

  function automatic logic [PINS-1:0] next_cause(input logic [PINS-1:0] cur,
                                                 input logic [PINS-1:0] kp,
                                                 input logic [PINS-1:0] rise,
                                                 input logic [PINS-1:0] lm,
                                                 input logic [PINS-1:0] lvl);
    return (lm & lvl) | (~lm & ((cur & kp) | rise));
  endfunction

  function automatic logic [PINS-1:0] drive_value(input logic [PINS-1:0] d,
                                                  input logic [PINS-1:0] bl,
                                                  input logic ph);
    return (bl & {PINS{ph}}) | (~bl & d);
  endfunction

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q1(sync1), .q2(sync2)
  );

  gpio_blink_timer #(.BITS(BLINK_BITS)) u_blink (
    .clk(clk), .rst_n(rst_n), .phase(blink_phase), .wrap(blink_wrap)
  );

  gpio_irq_merge #(.PINS(PINS), .GROUP(GROUP)) u_irq (
    .cause(cause), .edge_mask(edge_mask), .lvl_mask(lvl_mask), .irq(irq)
  );

  assign wsel     = word_of(reg_addr);
  assign adj_in   = sync2 ^ pol;
  assign edge_evt = adj_in & ~adj_prev;
  assign cause_wr = reg_we && (wsel == W_CAUSE);
  assign keep     = cause_wr ? reg_wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      dir_ctl   <= '1;
      blink_en  <= '0;
      pol       <= '0;
      edge_mask <= '0;
      lvl_mask  <= '0;
    end else if (reg_we) begin
      case (wsel)
        W_DOUT:  dout      <= reg_wdata;
        W_DIR:   dir_ctl   <= reg_wdata;
        W_BLINK: blink_en  <= reg_wdata;
        W_INV:   pol       <= reg_wdata;
        W_EDGE:  edge_mask <= reg_wdata;
        W_LEVEL: lvl_mask  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause    <= '0;
      adj_prev <= '0;
    end else begin
      cause    <= next_cause(cause, keep, edge_evt, lvl_mask, adj_in);
      adj_prev <= adj_in;
    end
  end

  always_comb begin
    case (wsel)
      W_DOUT:  reg_rdata = dout;
      W_DIR:   reg_rdata = dir_ctl;
      W_BLINK: reg_rdata = blink_en;
      W_INV:   reg_rdata = pol;
      W_DIN:   reg_rdata = adj_in;
      W_CAUSE: reg_rdata = cause;
      W_EDGE:  reg_rdata = edge_mask;
      default: reg_rdata = lvl_mask;
    endcase
  end

  assign pin_out = drive_value(dout, blink_en, blink_phase);
  assign pin_oe  = ~dir_ctl;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PINS  = 32,
  parameter int GROUP = 8,
  localparam int NGRP = PINS / GROUP
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] cause,
  input logic [PINS-1:0] edge_mask,
  input logic [PINS-1:0] lvl_mask,
  input logic [PINS-1:0] adj_in,
  input logic [PINS-1:0] sync1,
  input logic [PINS-1:0] pol,
  input logic [PINS-1:0] edge_evt,
  input logic            cause_wr,
  input logic            blink_wrap,
  input logic            blink_phase,
  input logic [NGRP-1:0] irq
);
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_mask | lvl_mask) == '0) |-> (irq == '0));

  // R6
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_evt & ~lvl_mask) != '0) |=>
      ((cause & $past(edge_evt & ~lvl_mask)) == $past(edge_evt & ~lvl_mask)));

  // R8
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mask != '0) |=> ((cause & $past(lvl_mask)) == ($past(adj_in) & $past(lvl_mask))));

  // R7
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_wr && edge_evt == '0 && lvl_mask == '0) |=> $stable(cause));

  // R4
  blink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_wrap |=> $stable(blink_phase));

  // R4
  blink_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blink_wrap |=> (blink_phase != $past(blink_phase)));

  // R5
  sync_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((adj_in ^ pol) == $past(sync1)));
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS), .GROUP(GROUP)) u_chk (.*);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  localparam int BB = 4;
  localparam int BPER = 1 << BB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.BLINK_BITS(BB)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_dout, m_dir, m_blink, m_inv, m_cause, m_em, m_lm, m_s1, m_s2, m_prev;
  int m_cnt;
  bit m_phase;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = 0; m_dir = '1; m_blink = 0; m_inv = 0; m_cause = 0;
      m_em = 0; m_lm = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0; m_phase = 0;
    end else begin
      logic [31:0] adj, nc;
      adj = m_s2 ^ m_inv;
      for (int i = 0; i < 32; i++) begin
        if (m_lm[i]) nc[i] = adj[i];
        else begin
          nc[i] = m_cause[i];
          if (reg_we && reg_addr[4:2] == 5 && !reg_wdata[i]) nc[i] = 1'b0;
          if (adj[i] && !m_prev[i]) nc[i] = 1'b1;
        end
      end
      m_cause = nc;
      m_prev = adj;
      if (reg_we) begin
        case (reg_addr[4:2])
          0: m_dout = reg_wdata;
          1: m_dir = reg_wdata;
          2: m_blink = reg_wdata;
          3: m_inv = reg_wdata;
          6: m_em = reg_wdata;
          7: m_lm = reg_wdata;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (m_cnt == BPER - 1) begin m_cnt = 0; m_phase = !m_phase; end
      else m_cnt++;
    end
  end

  function automatic logic [31:0] m_read(input int w);
    case (w)
      0: return m_dout;
      1: return m_dir;
      2: return m_blink;
      3: return m_inv;
      4: return m_s2 ^ m_inv;
      5: return m_cause;
      6: return m_em;
      default: return m_lm;
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [31:0] eo;
      logic [3:0] ei;
      for (int i = 0; i < 32; i++) eo[i] = m_blink[i] ? m_phase : m_dout[i];
      for (int g = 0; g < 4; g++) begin
        ei[g] = 1'b0;
        for (int j = 0; j < 8; j++)
          if (m_cause[g*8+j] && (m_em[g*8+j] || m_lm[g*8+j])) ei[g] = 1'b1;
      end
      if (reg_addr[4:2] == 4) chk("R5 data in", reg_rdata, m_read(4));
      else if (reg_addr[4:2] == 5) chk("R6 cause", reg_rdata, m_read(5));
      else chk("R2 readback", reg_rdata, m_read(int'(reg_addr[4:2])));
      chk("R4 pin_out", pin_out, eo);
      chk("R3 pin_oe", pin_oe, ~m_dir);
      chk("R10 irq", {28'd0, irq}, {28'd0, ei});
    end
  end

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(w * 4); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int w, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 5'(w * 4);
    #1 v = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1, v); chk("R1 dir reset", v, 32'hFFFF_FFFF);
    rd(5, v); chk("R1 cause reset", v, 0);
    rd(0, v); chk("R1 dout reset", v, 0);
    chk("R1 pin_oe reset", pin_oe, 0);
    chk("R1 irq reset", {28'd0, irq}, 0);

    // R2 readback and read-only data in
    wr(0, 32'hA5A5_0F0F); rd(0, v); chk("R2 dout", v, 32'hA5A5_0F0F);
    wr(6, 32'h1234_5678); rd(6, v); chk("R2 edge enable", v, 32'h1234_5678);
    wr(7, 32'h0F0F_0000); rd(7, v); chk("R2 level enable", v, 32'h0F0F_0000);
    wr(6, 0); wr(7, 0);
    wr(4, 32'hFFFF_FFFF); rd(4, v); chk("R2 data in ignores write", v, 0);

    // R3 active-low direction
    wr(1, 32'hFFFF_FF00);
    @(negedge clk); #1;
    chk("R3 pin_oe", pin_oe, 32'h0000_00FF);
    chk("R3 pin_out low byte", {24'd0, pin_out[7:0]}, 32'h0F);

    // R4 blink
    wr(2, 32'h1);
    @(negedge clk); #1 a = pin_out[0];
    repeat (BPER) @(negedge clk);
    #1 b = pin_out[0];
    chk("R4 blink toggles", {31'd0, b}, {31'd0, ~a});
    wr(2, 0);

    // R5 sync and data in; cause latches with enables clear
    pin_in[8] = 1'b1; settle();
    rd(4, v); chk("R5 data in", v, 32'h100);
    chk("R10 masked cause no irq", {28'd0, irq}, 0);
    wr(6, 32'h100);
    @(negedge clk); #1 chk("R10 group1 line", {28'd0, irq}, 32'h2);

    // R6 edge latch survives fall
    pin_in[0] = 1'b1; settle();
    pin_in[0] = 1'b0; settle();
    rd(5, v); chk("R6 edge held", v & 32'h101, 32'h101);

    // R7 selective then full clear
    wr(5, ~32'h1); rd(5, v); chk("R7 selective clear", v & 32'h101, 32'h100);
    wr(5, 0); rd(5, v); chk("R7 full clear", v, 0);
    chk("R7 irq gone", {28'd0, irq}, 0);

    // R8 level tracking
    wr(7, 32'h1_0000);
    pin_in[16] = 1'b1; settle();
    rd(5, v); chk("R8 level set", v & 32'h1_0000, 32'h1_0000);
    chk("R8 irq group2", {28'd0, irq}, 32'h4);
    wr(5, 0); @(negedge clk);
    rd(5, v); chk("R8 clear not lasting", v & 32'h1_0000, 32'h1_0000);
    pin_in[16] = 1'b0; settle();
    rd(5, v); chk("R8 level drop", v & 32'h1_0000, 0);
    chk("R8 irq drop", {28'd0, irq}, 0);

    // R9 inversion gives falling edge
    wr(3, 32'h0100_0000); settle();
    wr(5, 0); wr(6, 32'h0100_0000);
    rd(4, v); chk("R9 inverted data in", v & 32'h0100_0000, 32'h0100_0000);
    pin_in[24] = 1'b1; settle();
    rd(5, v); chk("R9 raw rise silent", v & 32'h0100_0000, 0);
    pin_in[24] = 1'b0; settle();
    rd(5, v); chk("R9 raw fall caught", v & 32'h0100_0000, 32'h0100_0000);
    chk("R9 irq group3", {28'd0, irq}, 32'h8);

    // random phase under per-cycle model compare
    wr(6, 32'h00FF_00F0); wr(7, 32'hFF00_0F00); wr(3, 32'h0F0F_0F0F);
    wr(2, 32'h8000_0001); wr(1, 32'h0);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      pin_in = $urandom;
      reg_addr = 5'($urandom_range(0, 7) * 4);
      if ((k % 13) == 0) begin
        reg_we = 1'b1; reg_addr = 5'd20; reg_wdata = $urandom;
      end else reg_we = 1'b0;
    end
    @(negedge clk); reg_we = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule